// File: doc/BRIEF.md
# Interrupt Source Controller (level and message sources)

This unit owns a bank of interrupt sources and feeds a downstream presentation unit. Each source is either level-sensitive or message-signalled. Each has a destination server number, a live priority, a saved priority and a small set of status flags. Priority 0xFF means the source is masked. Input events and configuration writes decide when a source should be offered. The unit then emits one request at a time on a valid/ready port. A request carries the global interrupt number (base offset plus source index), the priority and the server.

The presentation unit answers with three kinds of message. A reject means the offer was refused. An end-of-interrupt (EOI) closes a delivered level interrupt. A resend asks every source to try again. Refused message interrupts remember the refusal until a resend arrives. Level interrupts re-offer themselves on the next line edge, configuration write or resend while the line is still high. Message events that arrive while the source is masked are held until a later write unmasks it.

Top module: `intSourceUnit`

## Requirements
- R1: After reset no request is offered, and every source is masked (priority 0xFF) with all status flags clear. A message event on a source that has not been configured yet sets its held flag and offers nothing.
- R2: A message event (the source's `lineIn` bit high for one cycle) on an unmasked message source offers a request in the next cycle. The request carries number BASE+index (BASE defaults to 4096), the source's priority and its server.
- R3: A configuration write that unmasks a message source with a held event clears the hold and offers the source in the next cycle. A configuration write to a message source with no held event offers nothing.
- R4: A level source is offered when it is unmasked, its line is high and it is not marked sent. Offering it marks it sent, so a line held high produces exactly one request.
- R5: A reject or an EOI that targets a level source clears its sent mark. A following resend then offers it again if its line is still high.
- R6: A reject of a message source marks it refused. The next resend clears the mark and offers the source once. A further resend offers nothing.
- R7: An EOI aimed at a message source has no effect. A refused mark survives it.
- R8: A request never carries priority 0xFF. A queued source that is masked before its handshake is withdrawn. A withdrawn message source becomes held, and a withdrawn level source loses its sent mark, so unmasking offers it again.
- R9: Reject and EOI numbers are translated by subtracting BASE. Numbers below BASE or at BASE+NUM_SRC or above are ignored.
- R10: At most one request completes per cycle (presValid and presReady both high). Among waiting sources the lowest index goes first. A waiting request stays valid while presReady is low, unless a configuration write masks it.
- R11: A reset preserves each source's level/message type. Priorities return to 0xFF and status flags clear.
- R12: A level source whose line has fallen is not offered by a resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | NUM_SRC | Per-source input: line level for level sources, one-cycle event pulse for message sources |
| typeWrValid | input | 1 | Type write strobe |
| typeWrIdx | input | IDX_W | Source index for the type write |
| typeWrLevel | input | 1 | 1 = level-sensitive, 0 = message-signalled |
| cfgWrValid | input | 1 | Configuration write strobe |
| cfgWrIdx | input | IDX_W | Source index for the configuration write |
| cfgServer | input | SRV_W | New destination server |
| cfgPrio | input | 8 | New priority (0xFF masks) |
| cfgSavedPrio | input | 8 | New saved priority |
| presValid | output | 1 | Request offered |
| presReady | input | 1 | Presentation unit takes the request |
| presNum | output | NUM_W | Global interrupt number |
| presPrio | output | 8 | Request priority |
| presServer | output | SRV_W | Request destination server |
| rejValid | input | 1 | Reject message strobe |
| rejNum | input | NUM_W | Global number being rejected |
| eoiValid | input | 1 | EOI message strobe |
| eoiNum | input | NUM_W | Global number being closed |
| resendValid | input | 1 | Resend request strobe |

## Verification
Every input that changes source state is registered once, so its effect on `presValid` and the request fields shows at the very next cycle. A wrong status flag inside a source therefore shows on the port one cycle after the stimulus that should expose it. A lost refused mark shows as silence after a resend. A stuck sent mark blocks the re-offer after an EOI or reject. A held event that is not kept shows as nothing after the unmasking write. A withdrawn request that is not restored shows as a missing offer later. Translation faults show as a wrong source reacting to an out-of-range reject or EOI.

// File: rtl/srcIntPkg.sv
package srcIntPkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] MASK_PRIO = 8'hFF;
  localparam int STRB_IDX_W = 16;

  // control -> datapath strobes
  typedef struct packed {
    logic                  typeStb;
    logic                  typeLvl;
    logic [STRB_IDX_W-1:0] typeIdx;
    logic                  cfgStb;
    logic [STRB_IDX_W-1:0] cfgIdx;
    logic                  rejStb;
    logic [STRB_IDX_W-1:0] rejIdx;
    logic                  eoiStb;
    logic [STRB_IDX_W-1:0] eoiIdx;
    logic                  resendStb;
    logic                  grantStb;
    logic [STRB_IDX_W-1:0] grantIdx;
  } srcStrobes_t;

  // per-source state
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [PRIO_W-1:0] saved;
    logic              asserted;
    logic              sent;
    logic              refused;
    logic              held;
    logic              queued;
  } srcState_t;

  localparam srcState_t RESET_STATE = '{prio: MASK_PRIO, saved: MASK_PRIO, default: '0};
endpackage

// File: rtl/srcArbCtrl.sv
module srcArbCtrl
  import srcIntPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_W   = 16,
  parameter int BASE    = 4096,
  parameter int IDX_W   = 3
) (
  input  logic               typeWrValid,
  input  logic [IDX_W-1:0]   typeWrIdx,
  input  logic               typeWrLevel,
  input  logic               cfgWrValid,
  input  logic [IDX_W-1:0]   cfgWrIdx,
  input  logic               rejValid,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic               eoiValid,
  input  logic [NUM_W-1:0]   eoiNum,
  input  logic               resendValid,
  input  logic               presReady,
  input  logic [NUM_SRC-1:0] readyVec,
  output srcStrobes_t        strb,
  output logic               presValid
);
  localparam logic [NUM_W:0] BASE_X = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] SPAN_X = (NUM_W+1)'(NUM_SRC);

  logic [NUM_W:0] rejOff, eoiOff;
  logic           rejHit, eoiHit;
  logic [STRB_IDX_W-1:0] grantIdx;

  // translate global numbers back to local indices; a borrow means below BASE
  assign rejOff = {1'b0, rejNum} - BASE_X;
  assign eoiOff = {1'b0, eoiNum} - BASE_X;
  assign rejHit = rejValid && !rejOff[NUM_W] && (rejOff < SPAN_X);
  assign eoiHit = eoiValid && !eoiOff[NUM_W] && (eoiOff < SPAN_X);

  // fixed priority: lowest waiting index wins
  always_comb begin
    grantIdx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (readyVec[k]) grantIdx = STRB_IDX_W'(k);
    end
  end

  assign presValid = |readyVec;

  always_comb begin
    strb           = '0;
    strb.typeStb   = typeWrValid;
    strb.typeLvl   = typeWrLevel;
    strb.typeIdx   = STRB_IDX_W'(typeWrIdx);
    strb.cfgStb    = cfgWrValid;
    strb.cfgIdx    = STRB_IDX_W'(cfgWrIdx);
    strb.rejStb    = rejHit;
    strb.rejIdx    = STRB_IDX_W'(rejOff[IDX_W-1:0]);
    strb.eoiStb    = eoiHit;
    strb.eoiIdx    = STRB_IDX_W'(eoiOff[IDX_W-1:0]);
    strb.resendStb = resendValid;
    strb.grantStb  = presValid && presReady;
    strb.grantIdx  = grantIdx;
  end
endmodule

// File: rtl/srcStateBank.sv
module srcStateBank
  import srcIntPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_W   = 16,
  parameter int SRV_W   = 8,
  parameter int BASE    = 4096,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  srcStrobes_t        strb,
  input  logic [NUM_SRC-1:0] lineIn,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  logic [PRIO_W-1:0]  cfgSavedPrio,
  output logic [NUM_SRC-1:0] readyVec,
  output logic [NUM_W-1:0]   presNum,
  output logic [PRIO_W-1:0]  presPrio,
  output logic [SRV_W-1:0]   presServer
);
  logic [PRIO_W-1:0] prioArr [NUM_SRC];
  logic [SRV_W-1:0]  srvArr  [NUM_SRC];

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : gSrc
    localparam logic [STRB_IDX_W-1:0] MY_IDX = STRB_IDX_W'(gi);

    srcState_t        st, nx;
    logic [SRV_W-1:0] srvQ;
    logic             isLvl;
    logic             hitCfg, hitRej, hitEoi, hitGrant, hitType, maskN, trig;

    assign hitCfg   = strb.cfgStb   && (strb.cfgIdx   == MY_IDX);
    assign hitRej   = strb.rejStb   && (strb.rejIdx   == MY_IDX);
    assign hitEoi   = strb.eoiStb   && (strb.eoiIdx   == MY_IDX);
    assign hitGrant = strb.grantStb && (strb.grantIdx == MY_IDX);
    assign hitType  = strb.typeStb  && (strb.typeIdx  == MY_IDX);

    always_comb begin
      nx    = st;
      maskN = 1'b0;
      trig  = 1'b0;
      if (hitCfg) begin
        nx.prio  = cfgPrio;
        nx.saved = cfgSavedPrio;
      end
      maskN = (nx.prio == MASK_PRIO);
      if (hitGrant) nx.queued = 1'b0;

      if (isLvl) begin
        nx.asserted = lineIn[gi];
        nx.refused  = 1'b0;
        nx.held     = 1'b0;
        if (hitRej || hitEoi) nx.sent = 1'b0;
        if (nx.queued && maskN) begin
          nx.queued = 1'b0;
          nx.sent   = 1'b0;
        end
        trig = (lineIn[gi] != st.asserted) || hitCfg || strb.resendStb;
        if (trig && !maskN && nx.asserted && !nx.sent) begin
          nx.sent   = 1'b1;
          nx.queued = 1'b1;
        end
      end else begin
        nx.asserted = 1'b0;
        nx.sent     = 1'b0;
        if (hitRej) nx.refused = 1'b1;
        if (nx.queued && maskN) begin
          nx.queued = 1'b0;
          nx.held   = 1'b1;
        end
        if (lineIn[gi]) begin
          if (maskN) nx.held = 1'b1;
          else       nx.queued = 1'b1;
        end
        if (hitCfg && nx.held && !maskN) begin
          nx.held   = 1'b0;
          nx.queued = 1'b1;
        end
        if (strb.resendStb && nx.refused) begin
          nx.refused = 1'b0;
          if (!maskN) nx.queued = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st   <= RESET_STATE;
        srvQ <= '0;
      end else begin
        st <= nx;
        if (hitCfg) srvQ <= cfgServer;
      end
    end

    // type survives reset on purpose
    always_ff @(posedge clk) begin
      if (hitType) isLvl <= strb.typeLvl;
    end

    assign readyVec[gi] = st.queued && (st.prio != MASK_PRIO);
    assign prioArr[gi]  = st.prio;
    assign srvArr[gi]   = srvQ;
  end

  assign presNum    = NUM_W'(BASE) + NUM_W'(strb.grantIdx);
  assign presPrio   = prioArr[strb.grantIdx[IDX_W-1:0]];
  assign presServer = srvArr[strb.grantIdx[IDX_W-1:0]];
endmodule

// File: rtl/intSourceUnit.sv
module intSourceUnit
  import srcIntPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_W   = 16,
  parameter int SRV_W   = 8,
  parameter int BASE    = 4096,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] lineIn,
  input  logic               typeWrValid,
  input  logic [IDX_W-1:0]   typeWrIdx,
  input  logic               typeWrLevel,
  input  logic               cfgWrValid,
  input  logic [IDX_W-1:0]   cfgWrIdx,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  logic [PRIO_W-1:0]  cfgSavedPrio,
  output logic               presValid,
  input  logic               presReady,
  output logic [NUM_W-1:0]   presNum,
  output logic [PRIO_W-1:0]  presPrio,
  output logic [SRV_W-1:0]   presServer,
  input  logic               rejValid,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic               eoiValid,
  input  logic [NUM_W-1:0]   eoiNum,
  input  logic               resendValid
);
  srcStrobes_t        strb;
  logic [NUM_SRC-1:0] readyVec;

  srcArbCtrl #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE), .IDX_W(IDX_W)) uCtrl (
    .typeWrValid(typeWrValid), .typeWrIdx(typeWrIdx), .typeWrLevel(typeWrLevel),
    .cfgWrValid(cfgWrValid), .cfgWrIdx(cfgWrIdx),
    .rejValid(rejValid), .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .resendValid(resendValid), .presReady(presReady), .readyVec(readyVec),
    .strb(strb), .presValid(presValid)
  );

  srcStateBank #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .SRV_W(SRV_W), .BASE(BASE), .IDX_W(IDX_W)) uBank (
    .clk(clk), .rstN(rstN), .strb(strb), .lineIn(lineIn),
    .cfgServer(cfgServer), .cfgPrio(cfgPrio), .cfgSavedPrio(cfgSavedPrio),
    .readyVec(readyVec), .presNum(presNum), .presPrio(presPrio), .presServer(presServer)
  );
endmodule

// File: rtl/intSourceUnitChk.sv
module intSourceUnitChk #(
  parameter int NUM_SRC = 8,
  parameter int NUM_W   = 16,
  parameter int BASE    = 4096
) (
  input logic             clk,
  input logic             rstN,
  input logic             presValid,
  input logic             presReady,
  input logic [NUM_W-1:0] presNum,
  input logic [7:0]       presPrio,
  input logic             cfgWrValid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> !presValid);

  // R8
  unmasked_pres_chk: assert property (@(posedge clk) disable iff (!rstN)
    presValid |-> presPrio != 8'hFF);

  // R9
  num_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    presValid |-> (presNum >= NUM_W'(BASE)) && (presNum < NUM_W'(BASE + NUM_SRC)));

  // R10
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    presValid && !presReady && !cfgWrValid |=> presValid);

  // R10
  known_num_chk: assert property (@(posedge clk) disable iff (!rstN)
    presValid |-> !$isunknown(presNum));
endmodule

bind intSourceUnit intSourceUnitChk #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE)) uChk (
  .clk(clk), .rstN(rstN), .presValid(presValid), .presReady(presReady),
  .presNum(presNum), .presPrio(presPrio), .cfgWrValid(cfgWrValid)
);

// File: tb/sim_intSourceUnit.sv
module sim_intSourceUnit;
  localparam int N = 8;
  localparam int NW = 16;
  localparam int SW = 8;
  localparam int BASE = 4096;

  logic clk = 0, rstN = 0;
  logic [N-1:0] lineIn = '0;
  logic typeWrValid = 0, typeWrLevel = 0, cfgWrValid = 0;
  logic [2:0] typeWrIdx = '0, cfgWrIdx = '0;
  logic [SW-1:0] cfgServer = '0;
  logic [7:0] cfgPrio = 8'hFF, cfgSavedPrio = 8'hFF;
  logic presValid, presReady = 1;
  logic [NW-1:0] presNum, rejNum = '0, eoiNum = '0;
  logic [7:0] presPrio;
  logic [SW-1:0] presServer;
  logic rejValid = 0, eoiValid = 0, resendValid = 0;

  int checks = 0, errors = 0;
  int presCnt = 0, evCnt = 0;
  logic [7:0] prR [4];
  logic [SW-1:0] srvR [4];

  intSourceUnit #(.NUM_SRC(N), .NUM_W(NW), .SRV_W(SW), .BASE(BASE)) u0 (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .typeWrValid(typeWrValid), .typeWrIdx(typeWrIdx),
    .typeWrLevel(typeWrLevel), .cfgWrValid(cfgWrValid), .cfgWrIdx(cfgWrIdx), .cfgServer(cfgServer),
    .cfgPrio(cfgPrio), .cfgSavedPrio(cfgSavedPrio), .presValid(presValid), .presReady(presReady),
    .presNum(presNum), .presPrio(presPrio), .presServer(presServer), .rejValid(rejValid),
    .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum), .resendValid(resendValid));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] gnum(input int idx);
    return NW'(BASE + idx);
  endfunction

  task automatic expectPres(input int idx, input int prio, input int srv, input string tag);
    chk(presValid == 1'b1, tag, "presValid", presValid, 1);
    chk(presNum == gnum(idx), tag, "presNum", presNum, gnum(idx));
    chk(presPrio == 8'(prio), tag, "presPrio", presPrio, prio);
    chk(presServer == SW'(srv), tag, "presServer", presServer, srv);
  endtask

  task automatic expectNone(input string tag);
    chk(presValid == 1'b0, tag, "presValid idle", presValid, 0);
  endtask

  task automatic idle(); @(negedge clk); endtask

  task automatic setType(input int idx, input bit lvl);
    typeWrValid = 1; typeWrIdx = 3'(idx); typeWrLevel = lvl;
    @(negedge clk); typeWrValid = 0;
  endtask

  task automatic cfg(input int idx, input int srv, input int prio);
    cfgWrValid = 1; cfgWrIdx = 3'(idx); cfgServer = SW'(srv); cfgPrio = 8'(prio); cfgSavedPrio = 8'(prio);
    @(negedge clk); cfgWrValid = 0;
  endtask

  task automatic pulse(input int idx);
    lineIn[idx] = 1; @(negedge clk); lineIn[idx] = 0;
  endtask

  task automatic setLine(input int idx, input bit v);
    lineIn[idx] = v; @(negedge clk);
  endtask

  task automatic rej(input int num);
    rejValid = 1; rejNum = NW'(num); @(negedge clk); rejValid = 0;
  endtask

  task automatic eoi(input int num);
    eoiValid = 1; eoiNum = NW'(num); @(negedge clk); eoiValid = 0;
  endtask

  task automatic resend();
    resendValid = 1; @(negedge clk); resendValid = 0;
  endtask

  task automatic sampleRand();
    #1;
    if (presValid && presReady) begin
      int idx;
      idx = int'(presNum) - BASE;
      presCnt++;
      chk(idx >= 0 && idx < 4, "R2", "random number", presNum, BASE);
      if (idx >= 0 && idx < 4) begin
        chk(presPrio == prR[idx], "R2", "random prio", presPrio, prR[idx]);
        chk(presServer == srvR[idx], "R2", "random server", presServer, srvR[idx]);
      end
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    for (int i = 0; i < N; i++) setType(i, i >= 4);
    expectNone("R1");

    // R1/R3: masked event is held, unmask presents it
    pulse(0); expectNone("R1");
    cfg(0, 2, 5); expectPres(0, 5, 2, "R3");
    idle(); expectNone("R3");
    cfg(1, 1, 7); expectNone("R3");
    // R2
    pulse(1); expectPres(1, 7, 1, "R2");
    idle(); expectNone("R2");

    // R10: ordering and hold under back-pressure
    presReady = 0; lineIn[0] = 1; lineIn[1] = 1; idle(); lineIn[1:0] = '0;
    expectPres(0, 5, 2, "R10");
    idle(); expectPres(0, 5, 2, "R10");
    presReady = 1; idle(); expectPres(1, 7, 1, "R10");
    idle(); expectNone("R10");

    // R6
    rej(BASE + 1); expectNone("R6");
    resend(); expectPres(1, 7, 1, "R6");
    idle(); expectNone("R6");
    resend(); expectNone("R6");

    // R7: EOI leaves the refused mark
    rej(BASE); eoi(BASE); resend(); expectPres(0, 5, 2, "R7");
    idle(); expectNone("R7");

    // R4
    cfg(4, 9, 3); expectNone("R4");
    setLine(4, 1); expectPres(4, 3, 9, "R4");
    idle(); expectNone("R4");
    idle(); expectNone("R4");

    // R9: out-of-range numbers alias to index 4 if mistranslated
    eoi(BASE + 12); resend(); expectNone("R9");
    rej(BASE - 4); resend(); expectNone("R9");

    // R5
    eoi(BASE + 4); resend(); expectPres(4, 3, 9, "R5");
    idle(); expectNone("R5");
    rej(BASE + 4); resend(); expectPres(4, 3, 9, "R5");
    idle(); expectNone("R5");

    // R12
    setLine(4, 0); expectNone("R12");
    rej(BASE + 4); resend(); expectNone("R12");
    setLine(4, 1); expectPres(4, 3, 9, "R4");
    idle();

    // R8: message withdrawal
    cfg(2, 3, 4); expectNone("R8");
    presReady = 0; pulse(2); expectPres(2, 4, 3, "R8");
    cfg(2, 3, 8'hFF); expectNone("R8");
    presReady = 1; cfg(2, 3, 6); expectPres(2, 6, 3, "R8");
    idle(); expectNone("R8");
    // R8: level withdrawal
    presReady = 0; cfg(5, 1, 2); setLine(5, 1); expectPres(5, 2, 1, "R8");
    cfg(5, 1, 8'hFF); expectNone("R8");
    presReady = 1; cfg(5, 1, 2); expectPres(5, 2, 1, "R8");
    idle(); expectNone("R8");
    setLine(5, 0);

    // R11: reset keeps the type
    rstN = 0; idle(); idle(); rstN = 1; idle();
    expectNone("R11");
    cfg(4, 6, 2); expectPres(4, 2, 6, "R11");
    idle();
    pulse(0); expectNone("R1");
    cfg(0, 2, 5); expectPres(0, 5, 2, "R1");
    idle();
    setLine(4, 0); expectNone("R12");

    // random message traffic
    for (int i = 0; i < 4; i++) begin
      prR[i] = 8'($urandom % 255);
      srvR[i] = SW'($urandom);
      cfg(i, int'(srvR[i]), int'(prR[i]));
    end
    idle();
    for (int c = 0; c < 3000; c++) begin
      logic [3:0] ev;
      for (int k = 0; k < 4; k++) ev[k] = ($urandom % 8) == 0;
      evCnt += $countones(ev);
      lineIn[3:0] = ev;
      presReady = ($urandom % 4) != 0;
      sampleRand();
      @(negedge clk);
    end
    lineIn = '0; presReady = 1;
    repeat (N + 2) begin sampleRand(); @(negedge clk); end
    expectNone("R10");
    chk(presCnt > 0 && presCnt <= evCnt, "R10", "random count", presCnt, evCnt);
    finishRun();
  end
endmodule